// File: doc/BRIEF.md
# Tuner Status Interrupt Controller

This block turns two tuner events into one interrupt line for a host processor. The first event is a radio-status change: the 3-bit signal-strength level or the stereo indication takes a new value. The second event is the end of a tuning command, signalled by a one-cycle pulse from the tuning sequencer. Each event sets its own sticky flag. The host reads the flags through two status registers, and reading a register clears the flag it holds.

Each flag has an enable bit that lets it reach the interrupt pin. A polarity bit selects whether the pin is active high or active low. While the radio power bit is low, the pin output enable is off, so the pin floats, and the radio-change flag is held at 1. The status inputs are sampled once per clock. A change is found by comparing the new sample with the one taken on the cycle before.

Top module: `tuner_irq_ctrl`

## Requirements
- R1: During and right after synchronous reset, `rad_flag` is 1, `cmd_flag` is 0, `irq_oe` is 0 and `irq_out` is 0.
- R2: With power on, a value of `{stereo_ind, sig_level}` that differs from the value sampled on the previous clock edge sets `rad_flag` at that edge. The first edge after reset only primes the sampler and detects nothing. An unchanged value never sets the flag.
- R3: With power on and no radio change at the same edge, an `rd_radio_stat` strobe clears `rad_flag` at that edge.
- R4: While `pwr_on` is 0, `rad_flag` reads 1 whatever the reads and status inputs do. After power returns it stays 1 until it is read.
- R5: A `cmd_done` pulse sets `cmd_flag`, and an `rd_tune_stat` strobe clears it. A read of one register leaves the other register's flag unchanged.
- R6: When a set event and a clearing read of the same flag fall on the same edge, the flag ends set. This holds for both flags.
- R7: With `irq_pol` = 0, `irq_out` is 1 exactly when (`rad_flag` and `rad_ie`) or (`cmd_flag` and `cmd_ie`). It is updated on the same edge as the flags it depends on.
- R8: With `irq_pol` = 1, `irq_out` is the inverse of the R7 value, so the pin is active low.
- R9: `irq_oe` equals `pwr_on` as sampled at the last clock edge, so the pin floats while power is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on | input | 1 | Radio power bit (0 = standby) |
| irq_pol | input | 1 | Pin polarity: 0 active high, 1 active low |
| rad_ie | input | 1 | Enable for the radio-change flag onto the pin |
| cmd_ie | input | 1 | Enable for the command-end flag onto the pin |
| sig_level | input | FS_W (3) | Measured signal-strength code |
| stereo_ind | input | 1 | Stereo reception indicator |
| cmd_done | input | 1 | One-cycle pulse when a tuning command ends |
| rd_radio_stat | input | 1 | Read strobe of the radio status register |
| rd_tune_stat | input | 1 | Read strobe of the tune-position-high/status register |
| rad_flag | output | 1 | Sticky radio-change flag |
| cmd_flag | output | 1 | Sticky command-end flag |
| irq_out | output | 1 | Interrupt pin drive level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
Two collisions can happen on one clock edge. A status change can coincide with a read of the radio status register, and a command-end pulse can coincide with a read of the tune status register. The bench provokes each one by driving the change or pulse together with the matching read strobe for a single cycle. It judges the result by the flag staying 1 after that edge and by the interrupt pin going active when the source is enabled. A sweep over every pair of status values also checks that only a real difference sets the flag.

// File: rtl/tuner_irq_pkg.sv
package tuner_irq_pkg;
  localparam int unsigned SIG_W = 3;
  localparam int unsigned N_SRC = 2;

  typedef enum int unsigned {
    SRC_RADIO = 0,
    SRC_CMD   = 1
  } irq_src_e;
endpackage

// File: rtl/stat_change_det.sv
module stat_change_det #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_i,
  output logic         change_o,
  output logic         primed_o
);
  logic [W-1:0] samp_q;
  logic         primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      samp_q   <= stat_i;
      primed_q <= 1'b1;
    end
  end

  assign change_o = primed_q && (stat_i != samp_q);
  assign primed_o = primed_q;

  // R2: an input held steady for two edges raises no change
  p_steady_no_change_r2: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $stable(stat_i)) |-> !change_o);
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic force_i,
  output logic nxt_o,
  output logic flag_o
);
  logic flag_q;

  always_comb begin
    if (force_i || set_i) nxt_o = 1'b1;
    else if (clr_i)       nxt_o = 1'b0;
    else                  nxt_o = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= RST_VAL;
    else     flag_q <= nxt_o;
  end

  assign flag_o = flag_q;

  // R6: a set wins over a clearing read on the same edge
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> flag_o);
  // R3 and R5: a read with no set or force clears the flag
  p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i && !force_i) |=> !flag_o);
  // R4: the force input holds the flag high
  p_force_high_r4: assert property (@(posedge clk) disable iff (rst)
    force_i |=> flag_o);
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwr_i,
  input  logic         pol_i,
  input  logic [N-1:0] flag_nxt_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o,
  output logic         oe_o
);
  logic active;
  logic irq_q;
  logic oe_q;

  assign active = |(flag_nxt_i & en_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      irq_q <= active ^ pol_i;
      oe_q  <= pwr_i;
    end
  end

  assign irq_o = irq_q;
  assign oe_o  = oe_q;

  // R9: a standby sample turns the output enable off
  p_float_in_standby_r9: assert property (@(posedge clk) disable iff (rst)
    !pwr_i |=> !oe_o);
  // R7: no enabled source means the pin sits at its idle level
  p_idle_level_r7: assert property (@(posedge clk) disable iff (rst)
    ((flag_nxt_i & en_i) == '0) |=> (irq_o == $past(pol_i)));
endmodule

// File: rtl/tuner_irq_ctrl.sv
module tuner_irq_ctrl
  import tuner_irq_pkg::*;
#(
  parameter int unsigned FS_W = SIG_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_on,
  input  logic            irq_pol,
  input  logic            rad_ie,
  input  logic            cmd_ie,
  input  logic [FS_W-1:0] sig_level,
  input  logic            stereo_ind,
  input  logic            cmd_done,
  input  logic            rd_radio_stat,
  input  logic            rd_tune_stat,
  output logic            rad_flag,
  output logic            cmd_flag,
  output logic            irq_out,
  output logic            irq_oe
);
  localparam int unsigned STAT_W = FS_W + 1;
  localparam bit [N_SRC-1:0] RST_FLAGS = N_SRC'(1) << SRC_RADIO;

  logic [STAT_W-1:0] stat_vec;
  logic              stat_chg;
  logic              stat_primed;
  logic [N_SRC-1:0]  set_v, clr_v, force_v, nxt_v, flag_v, en_v;

  assign stat_vec = {stereo_ind, sig_level};

  stat_change_det #(.W(STAT_W)) u_chg (
    .clk      (clk),
    .rst      (rst),
    .stat_i   (stat_vec),
    .change_o (stat_chg),
    .primed_o (stat_primed)
  );

  always_comb begin
    set_v   = '0;
    clr_v   = '0;
    force_v = '0;
    en_v    = '0;
    set_v[SRC_RADIO]   = stat_chg;
    clr_v[SRC_RADIO]   = rd_radio_stat;
    force_v[SRC_RADIO] = !pwr_on;
    en_v[SRC_RADIO]    = rad_ie;
    set_v[SRC_CMD]     = cmd_done;
    clr_v[SRC_CMD]     = rd_tune_stat;
    en_v[SRC_CMD]      = cmd_ie;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    sticky_flag #(.RST_VAL(RST_FLAGS[g])) u_flag (
      .clk     (clk),
      .rst     (rst),
      .set_i   (set_v[g]),
      .clr_i   (clr_v[g]),
      .force_i (force_v[g]),
      .nxt_o   (nxt_v[g]),
      .flag_o  (flag_v[g])
    );
  end

  irq_pin_drv #(.N(N_SRC)) u_pin (
    .clk        (clk),
    .rst        (rst),
    .pwr_i      (pwr_on),
    .pol_i      (irq_pol),
    .flag_nxt_i (nxt_v),
    .en_i       (en_v),
    .irq_o      (irq_out),
    .oe_o       (irq_oe)
  );

  assign rad_flag = flag_v[SRC_RADIO];
  assign cmd_flag = flag_v[SRC_CMD];

  // R2: a status difference seen by a primed sampler sets the radio flag
  p_stat_change_r2: assert property (@(posedge clk) disable iff (rst)
    (stat_primed && (stat_vec != $past(stat_vec))) |=> rad_flag);
  // R5: a radio status read never touches the command-end flag
  p_cmd_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_radio_stat && !rd_tune_stat && !cmd_done) |=> (cmd_flag == $past(cmd_flag)));
  // R5: a command-end pulse sets its flag
  p_cmd_set_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> cmd_flag);
endmodule

// File: tb/tuner_irq_ctrl_tb_top.sv
module tuner_irq_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int FS_W  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_on = 1'b0, irq_pol = 1'b0, rad_ie = 1'b0, cmd_ie = 1'b0;
  logic [FS_W-1:0] sig_level = '0;
  logic stereo_ind = 1'b0, cmd_done = 1'b0;
  logic rd_radio_stat = 1'b0, rd_tune_stat = 1'b0;
  logic rad_flag, cmd_flag, irq_out, irq_oe;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  tuner_irq_ctrl #(.FS_W(FS_W)) dut_i (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .irq_pol(irq_pol),
    .rad_ie(rad_ie), .cmd_ie(cmd_ie), .sig_level(sig_level),
    .stereo_ind(stereo_ind), .cmd_done(cmd_done),
    .rd_radio_stat(rd_radio_stat), .rd_tune_stat(rd_tune_stat),
    .rad_flag(rad_flag), .cmd_flag(cmd_flag),
    .irq_out(irq_out), .irq_oe(irq_oe)
  );

  task automatic step();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic set_stat(input int v);
    sig_level  = v[FS_W-1:0];
    stereo_ind = v[FS_W];
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1", "rad_flag", rad_flag, 1'b1);
    chk("R1", "cmd_flag", cmd_flag, 1'b0);
    chk("R1", "irq_oe",   irq_oe,   1'b0);
    chk("R1", "irq_out",  irq_out,  1'b0);
    rst = 1'b0;
    step();

    // R4: standby holds the radio flag high through reads and changes
    rd_radio_stat = 1'b1; set_stat(5);
    step();
    rd_radio_stat = 1'b0;
    chk("R4", "rad_flag standby read", rad_flag, 1'b1);
    chk("R9", "irq_oe standby", irq_oe, 1'b0);

    pwr_on = 1'b1;
    step();
    chk("R9", "irq_oe on", irq_oe, 1'b1);
    chk("R4", "rad_flag held after power up", rad_flag, 1'b1);
    rd_radio_stat = 1'b1;
    step();
    rd_radio_stat = 1'b0;
    chk("R3", "rad_flag after read", rad_flag, 1'b0);

    // R2 sweep over every pair of status values
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        set_stat(a);
        step();
        rd_radio_stat = 1'b1;
        step();
        rd_radio_stat = 1'b0;
        chk("R3", "rad_flag cleared", rad_flag, 1'b0);
        set_stat(b);
        step();
        chk("R2", "rad_flag on change", rad_flag, logic'(a != b));
      end
    end
    rd_radio_stat = 1'b1; step(); rd_radio_stat = 1'b0;

    // R5 command-end flag and register independence
    cmd_done = 1'b1; step(); cmd_done = 1'b0;
    chk("R5", "cmd_flag set", cmd_flag, 1'b1);
    rd_radio_stat = 1'b1; step(); rd_radio_stat = 1'b0;
    chk("R5", "cmd_flag kept on radio read", cmd_flag, 1'b1);
    stereo_ind = ~stereo_ind; step();
    chk("R2", "rad_flag set", rad_flag, 1'b1);
    rd_tune_stat = 1'b1; step(); rd_tune_stat = 1'b0;
    chk("R5", "cmd_flag cleared", cmd_flag, 1'b0);
    chk("R5", "rad_flag kept on tune read", rad_flag, 1'b1);

    // R6 collisions with the interrupt enabled
    rd_radio_stat = 1'b1; step(); rd_radio_stat = 1'b0;
    rad_ie = 1'b1; cmd_ie = 1'b1; irq_pol = 1'b0;
    cmd_done = 1'b1; rd_tune_stat = 1'b1; step();
    cmd_done = 1'b0; rd_tune_stat = 1'b0;
    chk("R6", "cmd_flag set beats read", cmd_flag, 1'b1);
    chk("R6", "irq_out after cmd collision", irq_out, 1'b1);
    rd_tune_stat = 1'b1; step(); rd_tune_stat = 1'b0;
    sig_level = sig_level + 1'b1; rd_radio_stat = 1'b1; step();
    rd_radio_stat = 1'b0;
    chk("R6", "rad_flag set beats read", rad_flag, 1'b1);
    chk("R6", "irq_out after radio collision", irq_out, 1'b1);

    // R7 / R8 sweep over flags, enables and polarity
    for (int i = 0; i < 32; i++) begin
      logic rf, cf, rie, cie, pol, exp_irq;
      rf = i[0]; cf = i[1]; rie = i[2]; cie = i[3]; pol = i[4];
      rad_ie = rie; cmd_ie = cie; irq_pol = pol;
      rd_radio_stat = 1'b1; rd_tune_stat = 1'b1;
      step();
      rd_radio_stat = 1'b0; rd_tune_stat = 1'b0;
      if (rf) stereo_ind = ~stereo_ind;
      cmd_done = cf;
      step();
      cmd_done = 1'b0;
      exp_irq = ((rf & rie) | (cf & cie)) ^ pol;
      chk("R7", "rad_flag in sweep", rad_flag, rf);
      chk("R7", "cmd_flag in sweep", cmd_flag, cf);
      if (pol) chk("R8", "irq_out active low", irq_out, exp_irq);
      else     chk("R7", "irq_out active high", irq_out, exp_irq);
    end

    // R4 / R9 back to standby and out again
    rd_radio_stat = 1'b1; rd_tune_stat = 1'b1; step();
    rd_radio_stat = 1'b0; rd_tune_stat = 1'b0;
    pwr_on = 1'b0; step();
    chk("R9", "irq_oe off", irq_oe, 1'b0);
    chk("R4", "rad_flag forced", rad_flag, 1'b1);
    pwr_on = 1'b1; step();
    chk("R4", "rad_flag stays after wake", rad_flag, 1'b1);
    chk("R9", "irq_oe back on", irq_oe, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule